// File: doc/BRIEF.md
# Polyphase Interpolating Shaping Filter

This block up-samples one complex baseband channel by a factor of 4, 8 or 16. Each accepted I/Q sample is pushed into a short history line. The block then computes one output per interpolation phase. Every output is the dot product of the newest DS history entries with that phase's slice of the prototype impulse response. Each rail has a single multiplier and accumulator, and these walk the taps one per clock. One output therefore costs DS clocks, and a whole input sample costs DS × IP clocks. The input must arrive more slowly than the clock divided by DS × IP.

Each rail has 256 coefficient words, split into two halves of 128. A select input chooses the half where indexing starts. It is sampled only when a sample is accepted, so no sample's outputs ever draw on both halves. A prototype longer than 128 taps carries on into the other half. The write port can add an offset of 0, 4, 8 or 12 to the target address. With this offset, several copies of the filter can be given time-staggered coefficient sets and their outputs summed to form a wider channel.

The accumulator carries four guard bits above the full product. Each output is rounded to 20 bits with saturation. A sample that arrives while the engine is still busy is discarded, and a one-cycle overrun pulse marks the drop.

Top module: `poly_interp_fir`

## Requirements
- R1: After reset, out_valid and overrun are 0 and in_ready is 1.
- R2: Each accepted sample yields exactly IP out_valid strobes. IP is 4 for ip_sel=0, 8 for ip_sel=1, and 16 for ip_sel=2 or 3.
- R3: The output of phase p is round_sat(sum over k<DS of x[k]·h[idx]), where idx = k·IP + p and x[0] is the newest sample. DS is ds_sel limited to the range 4..16, so 0..3 act as 4 and 17..31 act as 16. I and Q use separate coefficient sets.
- R4: in_ready is low for exactly DS·IP cycles after the accepting edge. The strobe for phase p is seen on the cycle after (p+1)·DS busy cycles, so phase 0 appears after exactly DS.
- R5: bank_sel is captured on the accepting edge. Changes to it while busy do not affect that sample's outputs.
- R6: Tap index idx reads word (bank·128 + idx) mod 256, so spans beyond 128 continue into the other half.
- R7: A write with coef_we=1 stores coef_data at word (coef_addr + 4·load_shift) mod 256. It goes to the I set when coef_rail=0 and to the Q set when coef_rail=1.
- R8: Outputs equal floor((acc + 2^14) / 2^15), limited to the range −524288..524287.
- R9: When in_valid is high while in_ready is low, that sample is discarded, the history is unchanged, and overrun is high for the next cycle.
- R10: Reset clears the history to zero. Each accepted sample shifts the history by one, and the new sample goes to position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ip_sel | input | 2 | Interpolation factor code |
| ds_sel | input | 5 | Tap span (limited to the range 4..16) |
| bank_sel | input | 1 | Starting coefficient half |
| load_shift | input | 2 | Write address offset in steps of 4 |
| coef_we | input | 1 | Coefficient write enable |
| coef_rail | input | 1 | 0 = I set, 1 = Q set |
| coef_addr | input | 8 | Coefficient word address |
| coef_data | input | 16 | Two's complement coefficient |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | Engine idle |
| in_i | input | 16 | In-phase sample |
| in_q | input | 16 | Quadrature sample |
| out_valid | output | 1 | Output phase strobe |
| out_i | output | 20 | In-phase output |
| out_q | output | 20 | Quadrature output |
| overrun | output | 1 | Dropped-sample pulse |

## Verification
The bench builds the block with its default parameters: 16-bit samples and coefficients, a 20-bit output, a span of up to 16 taps and 128-word halves. These values make the full 16×16 case reachable. That case reads all 256 words and wraps across both halves. With extreme operands, the same settings drive the accumulator to exactly one step past the positive output limit, which exercises saturation. Small operands place the rounding point at exactly one half.

// File: rtl/poly_interp_fir.sv
module poly_interp_fir #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int OW = 20,
  parameter int MAX_DS = 16,
  parameter int BANK_WORDS = 128,
  parameter int GUARD = 4
)(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [1:0]                          ip_sel,
  input  logic [$clog2(MAX_DS+1)-1:0]         ds_sel,
  input  logic                                bank_sel,
  input  logic [1:0]                          load_shift,
  input  logic                                coef_we,
  input  logic                                coef_rail,
  input  logic [$clog2(2*BANK_WORDS)-1:0]     coef_addr,
  input  logic [CW-1:0]                       coef_data,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [DW-1:0]                       in_i,
  input  logic [DW-1:0]                       in_q,
  output logic                                out_valid,
  output logic [OW-1:0]                       out_i,
  output logic [OW-1:0]                       out_q,
  output logic                                overrun
);
  localparam int AW    = $clog2(2*BANK_WORDS);
  localparam int DEPTH = 2*BANK_WORDS;
  localparam int DSW   = $clog2(MAX_DS+1);
  localparam int TW    = $clog2(MAX_DS);
  localparam int PW    = DW + CW;
  localparam int ACCW  = PW + GUARD;
  localparam int RSH   = CW - 1;
  localparam logic signed [ACCW:0] OMAX = (2**(OW-1)) - 1;
  localparam logic signed [ACCW:0] OMIN = -(2**(OW-1));

  logic signed [CW-1:0] mem_i [DEPTH];
  logic signed [CW-1:0] mem_q [DEPTH];
  logic signed [DW-1:0] hist_i [MAX_DS];
  logic signed [DW-1:0] hist_q [MAX_DS];

  logic            busy, bank_q;
  logic [4:0]      ip_q;
  logic [DSW-1:0]  ds_q;
  logic [3:0]      phase;
  logic [TW-1:0]   tap;
  logic signed [ACCW-1:0] acc_i, acc_q, base_i, base_q, acc_i_nx, acc_q_nx;
  logic signed [PW-1:0]   prod_i, prod_q;

  wire [4:0] ip_n = (ip_sel == 2'd0) ? 5'd4 : (ip_sel == 2'd1) ? 5'd8 : 5'd16;
  wire [DSW-1:0] ds_n = (ds_sel < DSW'(4)) ? DSW'(4) :
                        (ds_sel > DSW'(MAX_DS)) ? DSW'(MAX_DS) : ds_sel;
  wire accept = in_valid && !busy;
  assign in_ready = !busy;

  wire [AW-1:0] wr_addr = coef_addr + AW'({load_shift, 2'b00});
  wire [AW-1:0] rd_addr = (bank_q ? AW'(BANK_WORDS) : AW'(0)) + AW'(tap) * AW'(ip_q) + AW'(phase);

  always_ff @(posedge clk)
    if (coef_we) begin
      if (coef_rail) mem_q[wr_addr] <= coef_data;
      else           mem_i[wr_addr] <= coef_data;
    end

  assign prod_i   = hist_i[tap] * mem_i[rd_addr];
  assign prod_q   = hist_q[tap] * mem_q[rd_addr];
  assign base_i   = (tap == '0) ? '0 : acc_i;
  assign base_q   = (tap == '0) ? '0 : acc_q;
  assign acc_i_nx = base_i + ACCW'(prod_i);
  assign acc_q_nx = base_q + ACCW'(prod_q);

  wire last_tap   = DSW'(tap) == ds_q - DSW'(1);
  wire last_phase = {1'b0, phase} == ip_q - 5'd1;

  function automatic logic [OW-1:0] rnd_sat(input logic signed [ACCW-1:0] a);
    logic signed [ACCW:0] s;
    s = {a[ACCW-1], a} + (ACCW+1)'(1 << (RSH-1));
    s = s >>> RSH;
    if (s > OMAX) s = OMAX;
    if (s < OMIN) s = OMIN;
    return s[OW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; bank_q <= 1'b0; ip_q <= 5'd4; ds_q <= DSW'(4);
      phase <= '0; tap <= '0; acc_i <= '0; acc_q <= '0;
      out_valid <= 1'b0; out_i <= '0; out_q <= '0; overrun <= 1'b0;
      for (int j = 0; j < MAX_DS; j++) begin
        hist_i[j] <= '0;
        hist_q[j] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      overrun   <= in_valid && busy;
      if (accept) begin
        busy <= 1'b1; ip_q <= ip_n; ds_q <= ds_n; bank_q <= bank_sel;
        phase <= '0; tap <= '0;
        for (int j = MAX_DS-1; j > 0; j--) begin
          hist_i[j] <= hist_i[j-1];
          hist_q[j] <= hist_q[j-1];
        end
        hist_i[0] <= in_i;
        hist_q[0] <= in_q;
      end else if (busy) begin
        acc_i <= acc_i_nx;
        acc_q <= acc_q_nx;
        if (last_tap) begin
          tap <= '0;
          phase <= phase + 4'd1;
          out_valid <= 1'b1;
          out_i <= rnd_sat(acc_i_nx);
          out_q <= rnd_sat(acc_q_nx);
          if (last_phase) busy <= 1'b0;
        end else begin
          tap <= tap + TW'(1);
        end
      end
    end
  end

  assert_drop_keeps_history_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> (overrun && $stable(hist_i[0]) && $stable(hist_q[0])));
  assert_bank_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bank_q));
  assert_strobe_after_work_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));
  assert_counters_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (DSW'(tap) < ds_q && {1'b0, phase} < ip_q));
  assert_fresh_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tap == '0 && phase == '0));
endmodule

// File: tb/sim_poly_interp_fir.sv
module sim_poly_interp_fir;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ip_sel = '0, load_shift = '0;
  logic [4:0] ds_sel = 5'd4;
  logic bank_sel = 1'b0, coef_we = 1'b0, coef_rail = 1'b0, in_valid = 1'b0;
  logic [7:0] coef_addr = '0;
  logic [15:0] coef_data = '0, in_i = '0, in_q = '0;
  logic in_ready, out_valid, overrun;
  logic [19:0] out_i, out_q;

  poly_interp_fir u0 (.clk(clk), .rst_n(rst_n), .ip_sel(ip_sel), .ds_sel(ds_sel), .bank_sel(bank_sel),
    .load_shift(load_shift), .coef_we(coef_we), .coef_rail(coef_rail), .coef_addr(coef_addr),
    .coef_data(coef_data), .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .overrun(overrun));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int mi [256], mq [256], hi [16], hq [16];
  int last_i, last_q;

  // {bank, ip_sel, ds_sel, i, q}
  localparam logic [39:0] VEC [8] = '{
    {1'b0, 2'd0, 5'd4,  16'd1200,   -16'sd800},
    {1'b0, 2'd0, 5'd5,  -16'sd30000, 16'd25000},
    {1'b1, 2'd1, 5'd6,  16'd7777,   -16'sd4321},
    {1'b0, 2'd1, 5'd12, -16'sd1,     16'd32767},
    {1'b1, 2'd2, 5'd7,  -16'sd32768, 16'd100},
    {1'b0, 2'd3, 5'd8,  16'd15000,  -16'sd15000},
    {1'b1, 2'd0, 5'd2,  16'd500,     16'd600},
    {1'b0, 2'd0, 5'd20, -16'sd2000,  16'd3000}
  };

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int rsat(input longint s);
    longint r = (s + 64'sd16384) >>> 15;
    if (r > 524287) r = 524287;
    if (r < -524288) r = -524288;
    return int'(r);
  endfunction

  task automatic wr(input bit rail, input int addr, input int data, input int sh);
    @(negedge clk);
    coef_we = 1'b1; coef_rail = rail; coef_addr = addr[7:0]; coef_data = data[15:0]; load_shift = sh[1:0];
    if (rail) mq[(addr + 4*sh) % 256] = data; else mi[(addr + 4*sh) % 256] = data;
    @(negedge clk);
    coef_we = 1'b0; load_shift = '0;
  endtask

  task automatic send(input int ipc, input int dsc, input int bk, input int si, input int sq,
                      input int mode, input string r);
    int ipn, dsn, n, low, first;
    longint ei [16], eq [16];
    ipn = (ipc == 0) ? 4 : (ipc == 1) ? 8 : 16;
    dsn = (dsc < 4) ? 4 : (dsc > 16) ? 16 : dsc;
    @(negedge clk);
    ip_sel = ipc[1:0]; ds_sel = dsc[4:0]; bank_sel = bk[0];
    in_i = si[15:0]; in_q = sq[15:0]; in_valid = 1'b1;
    for (int j = 15; j > 0; j--) begin hi[j] = hi[j-1]; hq[j] = hq[j-1]; end
    hi[0] = si; hq[0] = sq;
    for (int p = 0; p < ipn; p++) begin
      longint a = 0, b = 0;
      for (int k = 0; k < dsn; k++) begin
        a += longint'(hi[k]) * mi[(bk*128 + k*ipn + p) % 256];
        b += longint'(hq[k]) * mq[(bk*128 + k*ipn + p) % 256];
      end
      ei[p] = rsat(a); eq[p] = rsat(b);
    end
    @(negedge clk);
    in_valid = 1'b0;
    n = 0; low = 0; first = -1;
    forever begin
      if (out_valid) begin
        if (n == 0) first = low;
        if (n < 16) begin
          chk({r, " I"}, longint'($signed(out_i)), ei[n]);
          chk({r, " Q"}, longint'($signed(out_q)), eq[n]);
        end
        last_i = $signed(out_i); last_q = $signed(out_q);
        n++;
      end
      if (in_ready || low > 400) break;
      if (mode == 1 && low == 2) begin in_valid = 1'b1; in_i = 16'h1234; in_q = 16'h4321; end
      if (mode == 1 && low == 3) begin in_valid = 1'b0; chk("R9 overrun pulse", overrun, 1); end
      if (mode == 2 && low == 2) bank_sel = ~bk[0];
      low++;
      @(negedge clk);
    end
    chk({r, " R2 strobe count"}, n, ipn);
    chk({r, " R4 busy cycles"}, low, dsn*ipn);
    chk({r, " R4 first phase"}, first, dsn);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 16; j++) begin hi[j] = 0; hq[j] = 0; end
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 overrun", overrun, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < 256; j++) begin mi[j] = 0; mq[j] = 0; end
    do_reset();
    for (int a = 0; a < 256; a++) begin
      wr(1'b0, a, ((a*73 + 11) % 1999 - 999) * 16, 0);
      wr(1'b1, a, ((a*151 + 7) % 2047 - 1023) * 15, 0);
    end
    send(0, 4, 0, 20000, -15000, 0, "R10 first after reset");
    for (int v = 0; v < 8; v++)
      send(int'(VEC[v][38:37]), int'(VEC[v][36:32]), int'(VEC[v][39]),
           int'($signed(VEC[v][31:16])), int'($signed(VEC[v][15:0])), 0, "R3 table");
    send(1, 6, 0, 9000, -9000, 2, "R5 bank flip while busy");
    send(1, 6, 1, 4000, 4000, 0, "R5 new bank next sample");
    send(0, 5, 0, -12345, 23456, 1, "R9 drop while busy");
    send(0, 5, 0, 111, -222, 0, "R9 history untouched");
    send(2, 16, 1, 31000, -31000, 0, "R6 wrap from upper half");
    send(2, 16, 0, -7000, 8000, 0, "R6 full span lower half");
    wr(1'b0, 0, 12345, 3);
    wr(1'b1, 255, -9876, 1);
    send(0, 4, 0, 3000, 2000, 0, "R7 shifted write");
    for (int a = 0; a < 256; a++) begin
      wr(1'b0, a, -32768, 0);
      wr(1'b1, a, 1, 0);
    end
    for (int s = 0; s < 16; s++) send(2, 16, 0, -32768, 0, 0, "R8 fill");
    chk("R8 positive saturation", last_i, 524287);
    send(2, 16, 0, -32768, 16384, 0, "R8 half rounds up");
    chk("R8 round half up", last_q, 1);
    send(2, 16, 0, -32768, -16385, 0, "R8 small negative");
    chk("R8 -1 rounds to 0", last_q, 0);
    do_reset();
    send(0, 16, 0, 1000, -1000, 0, "R10 history cleared by reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule